// File: doc/BRIEF.md
# Security Configuration Control Register

This block holds the 32-bit control word that sets how a processor core handles its two security worlds. The word lives in the system-register space. A single access port reaches it, and the port decides per access whether the requester may touch the word. Only privilege level 3 may read or write it. A secure level-1 requester is sent to level 3 as a trap. Every other requester is refused. A refused or trapped access leaves the word as it was, and the data bus returns zero.

The stored fields drive several decisions at once, all combinational from the stored word and the current mode inputs:

- the security state the core is in;
- whether IRQs, fast interrupts and external aborts go to the monitor handler or to their own handlers;
- whether a wait-for-interrupt or wait-for-event instruction that would really suspend is trapped to the monitor;
- whether a hypervisor call is undefined;
- whether a secure monitor call is undefined, or is taken first by a hypervisor trap;
- whether a secure-state fetch from non-secure memory is blocked.

Top module: `secfg_ctrl`

## Requirements
- R1: Writable fields sit at bits 0 (nonsec), 1 (IRQ to monitor), 2 (fast interrupt to monitor), 3 (external abort to monitor), 4 and 5 (mask-writable flags), 7 (monitor call off), 8 (hypervisor call on), 9 (fetch lock), 12 (wait-for-interrupt trap) and 13 (wait-for-event trap). All other bits read as zero, and writes to them are dropped (write mask 0x000033BF).
- R2: After reset the stored word is 0x00000000.
- R3: With priv_lvl 3 (encoding 0 user, 1 kernel, 2 hypervisor, 3 monitor), a read returns the stored word. A write becomes visible on the cycle after the strobe.
- R4: With priv_lvl 1 and the effective state secure, acc_trap is 1. With priv_lvl 0 or 2, or priv_lvl 1 in the non-secure state, acc_deny is 1. In both cases the word is unchanged and acc_rdata is 0.
- R5: eff_nonsec is 1 only when bit 0 is 1 and mon_mode is 0.
- R6: Each of irq_to_mon, fiq_to_mon and abt_to_mon equals its routing bit (bits 1, 2 and 3). A 0 means the exception goes to its own handler.
- R7: wfi_trap is 1 when wfi_exec, bit 12 set, mon_mode 0, no wake_pending and no other_exc. wfe_trap is the same with bit 13, and it also needs event_reg to be 0.
- R8: hvc_undef is 1 for hvc_exec unless bit 8 is 1, the state is non-secure, and priv_lvl is 1 or 2.
- R9: smc_to_hyp is 1 for smc_exec with smc_hyp_trap, the non-secure state and priv_lvl 1. Otherwise smc_undef is 1 when bit 7 is set or priv_lvl is 0.
- R10: fetch_block is 1 when fetch_ns_attr, bit 9 set and the effective state secure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 write, 0 read |
| acc_wdata | input | 32 | Write data |
| priv_lvl | input | 2 | Requester privilege level |
| mon_mode | input | 1 | Core is in monitor mode |
| acc_rdata | output | 32 | Read data, zero unless permitted read |
| acc_trap | output | 1 | Access trapped to level 3 |
| acc_deny | output | 1 | Access refused |
| eff_nonsec | output | 1 | Effective non-secure state |
| irq_to_mon | output | 1 | IRQ routed to monitor |
| fiq_to_mon | output | 1 | Fast interrupt routed to monitor |
| abt_to_mon | output | 1 | External abort routed to monitor |
| wfi_exec | input | 1 | Wait-for-interrupt executing |
| wfe_exec | input | 1 | Wait-for-event executing |
| wake_pending | input | 1 | Wake-up event pending |
| event_reg | input | 1 | Event register set |
| other_exc | input | 1 | Instruction raises another exception |
| wfi_trap | output | 1 | Trap wait-for-interrupt to monitor |
| wfe_trap | output | 1 | Trap wait-for-event to monitor |
| hvc_exec | input | 1 | Hypervisor call executing |
| hvc_undef | output | 1 | Hypervisor call undefined |
| smc_exec | input | 1 | Monitor call executing |
| smc_hyp_trap | input | 1 | Hypervisor traps monitor calls |
| smc_to_hyp | output | 1 | Monitor call taken by hypervisor trap |
| smc_undef | output | 1 | Monitor call undefined |
| fetch_ns_attr | input | 1 | Fetch targets non-secure memory |
| fetch_block | output | 1 | Fetch not permitted |

## Verification
The assertions assume that reset is asserted at time zero and that priv_lvl and mon_mode are known whenever acc_valid is high. They also take the execute and fetch qualifiers as single-cycle level inputs, with no ordering between them. The bench changes every input only on the falling clock edge. It keeps mon_mode low during access tests, so that the expected permission depends only on the stored state bit. It raises mon_mode only in the directed decode checks.

// File: rtl/secfg_pkg.sv
package secfg_pkg;

    localparam int CFG_W = 32;
    localparam logic [CFG_W-1:0] CFG_WMASK = 32'h0000_33BF;

    localparam int B_NONSEC  = 0;
    localparam int B_IRQMON  = 1;
    localparam int B_FIQMON  = 2;
    localparam int B_ABTMON  = 3;
    localparam int B_FMASKW  = 4;
    localparam int B_AMASKW  = 5;
    localparam int B_SMCOFF  = 7;
    localparam int B_HVCON   = 8;
    localparam int B_FLOCK   = 9;
    localparam int B_WFITRAP = 12;
    localparam int B_WFETRAP = 13;

    typedef enum logic [1:0] {
        LVL_USER = 2'd0,
        LVL_KERN = 2'd1,
        LVL_HYP  = 2'd2,
        LVL_MON  = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_OK   = 2'd1,
        ACC_TRAP = 2'd2,
        ACC_DENY = 2'd3
    } acc_res_e;

    typedef struct packed {
        logic wfe_trap;
        logic wfi_trap;
        logic fetch_lock;
        logic hvc_on;
        logic smc_off;
        logic amask_w;
        logic fmask_w;
        logic abt_mon;
        logic fiq_mon;
        logic irq_mon;
        logic nonsec;
    } cfg_t;

    function automatic cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
        cfg_t c;
        c.nonsec     = w[B_NONSEC];
        c.irq_mon    = w[B_IRQMON];
        c.fiq_mon    = w[B_FIQMON];
        c.abt_mon    = w[B_ABTMON];
        c.fmask_w    = w[B_FMASKW];
        c.amask_w    = w[B_AMASKW];
        c.smc_off    = w[B_SMCOFF];
        c.hvc_on     = w[B_HVCON];
        c.fetch_lock = w[B_FLOCK];
        c.wfi_trap   = w[B_WFITRAP];
        c.wfe_trap   = w[B_WFETRAP];
        return c;
    endfunction

    function automatic acc_res_e acc_classify(input logic valid, input priv_e lvl,
                                              input logic secure);
        if (!valid)                      return ACC_IDLE;
        if (lvl == LVL_MON)              return ACC_OK;
        if (lvl == LVL_KERN && secure)   return ACC_TRAP;
        return ACC_DENY;
    endfunction

endpackage

// File: rtl/secfg_store.sv
module secfg_store
    import secfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg_q
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (wr_en)
            cfg_q <= wdata & CFG_WMASK;
    end
endmodule

// File: rtl/secfg_access.sv
module secfg_access
    import secfg_pkg::*;
(
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [1:0]       priv_lvl,
    input  logic             eff_secure,
    input  logic [CFG_W-1:0] cfg_q,
    output logic [CFG_W-1:0] acc_rdata,
    output logic             acc_trap,
    output logic             acc_deny,
    output logic             wr_en
);
    acc_res_e res;

    always_comb begin
        res       = acc_classify(acc_valid, priv_e'(priv_lvl), eff_secure);
        acc_trap  = (res == ACC_TRAP);
        acc_deny  = (res == ACC_DENY);
        wr_en     = (res == ACC_OK) && acc_write;
        acc_rdata = ((res == ACC_OK) && !acc_write) ? cfg_q : '0;
    end
endmodule

// File: rtl/secfg_decode.sv
module secfg_decode
    import secfg_pkg::*;
(
    input  cfg_t       cfg,
    input  logic       mon_mode,
    input  logic [1:0] priv_lvl,
    output logic       eff_nonsec,
    output logic       irq_to_mon,
    output logic       fiq_to_mon,
    output logic       abt_to_mon,
    input  logic       wfi_exec,
    input  logic       wfe_exec,
    input  logic       wake_pending,
    input  logic       event_reg,
    input  logic       other_exc,
    output logic       wfi_trap,
    output logic       wfe_trap,
    input  logic       hvc_exec,
    output logic       hvc_undef,
    input  logic       smc_exec,
    input  logic       smc_hyp_trap,
    output logic       smc_to_hyp,
    output logic       smc_undef,
    input  logic       fetch_ns_attr,
    output logic       fetch_block
);
    logic would_suspend;
    logic hvc_ok;
    priv_e lvl;

    always_comb begin
        lvl           = priv_e'(priv_lvl);
        eff_nonsec    = cfg.nonsec && !mon_mode;
        irq_to_mon    = cfg.irq_mon;
        fiq_to_mon    = cfg.fiq_mon;
        abt_to_mon    = cfg.abt_mon;
        would_suspend = !mon_mode && !wake_pending && !other_exc;
        wfi_trap      = wfi_exec && cfg.wfi_trap && would_suspend;
        wfe_trap      = wfe_exec && cfg.wfe_trap && would_suspend && !event_reg;
        hvc_ok        = cfg.hvc_on && eff_nonsec && (lvl == LVL_KERN || lvl == LVL_HYP);
        hvc_undef     = hvc_exec && !hvc_ok;
        smc_to_hyp    = smc_exec && smc_hyp_trap && eff_nonsec && (lvl == LVL_KERN);
        smc_undef     = smc_exec && !smc_to_hyp && (cfg.smc_off || lvl == LVL_USER);
        fetch_block   = fetch_ns_attr && cfg.fetch_lock && !eff_nonsec;
    end
endmodule

// File: rtl/secfg_ctrl.sv
module secfg_ctrl
    import secfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [31:0] acc_wdata,
    input  logic [1:0]  priv_lvl,
    input  logic        mon_mode,
    output logic [31:0] acc_rdata,
    output logic        acc_trap,
    output logic        acc_deny,
    output logic        eff_nonsec,
    output logic        irq_to_mon,
    output logic        fiq_to_mon,
    output logic        abt_to_mon,
    input  logic        wfi_exec,
    input  logic        wfe_exec,
    input  logic        wake_pending,
    input  logic        event_reg,
    input  logic        other_exc,
    output logic        wfi_trap,
    output logic        wfe_trap,
    input  logic        hvc_exec,
    output logic        hvc_undef,
    input  logic        smc_exec,
    input  logic        smc_hyp_trap,
    output logic        smc_to_hyp,
    output logic        smc_undef,
    input  logic        fetch_ns_attr,
    output logic        fetch_block
);
    logic [CFG_W-1:0] cfg_q;
    logic             wr_en;
    cfg_t             cfg;

    assign cfg = cfg_unpack(cfg_q);

    secfg_store u_store (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .wdata (acc_wdata),
        .cfg_q (cfg_q)
    );

    secfg_access u_access (
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .priv_lvl   (priv_lvl),
        .eff_secure (!eff_nonsec),
        .cfg_q      (cfg_q),
        .acc_rdata  (acc_rdata),
        .acc_trap   (acc_trap),
        .acc_deny   (acc_deny),
        .wr_en      (wr_en)
    );

    secfg_decode u_decode (
        .cfg           (cfg),
        .mon_mode      (mon_mode),
        .priv_lvl      (priv_lvl),
        .eff_nonsec    (eff_nonsec),
        .irq_to_mon    (irq_to_mon),
        .fiq_to_mon    (fiq_to_mon),
        .abt_to_mon    (abt_to_mon),
        .wfi_exec      (wfi_exec),
        .wfe_exec      (wfe_exec),
        .wake_pending  (wake_pending),
        .event_reg     (event_reg),
        .other_exc     (other_exc),
        .wfi_trap      (wfi_trap),
        .wfe_trap      (wfe_trap),
        .hvc_exec      (hvc_exec),
        .hvc_undef     (hvc_undef),
        .smc_exec      (smc_exec),
        .smc_hyp_trap  (smc_hyp_trap),
        .smc_to_hyp    (smc_to_hyp),
        .smc_undef     (smc_undef),
        .fetch_ns_attr (fetch_ns_attr),
        .fetch_block   (fetch_block)
    );
endmodule

// File: rtl/secfg_chk.sv
module secfg_chk
    import secfg_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [31:0] acc_wdata,
    input logic [1:0]  priv_lvl,
    input logic        mon_mode,
    input logic [31:0] acc_rdata,
    input logic        acc_trap,
    input logic        acc_deny,
    input logic        eff_nonsec,
    input logic        wfi_trap,
    input logic        wfe_trap,
    input logic        hvc_exec,
    input logic        hvc_undef,
    input logic        smc_to_hyp,
    input logic        smc_undef,
    input logic [31:0] cfg_q
);
    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (acc_rdata & ~CFG_WMASK) == '0);

    p_reset_zero_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> cfg_q == '0);

    p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && priv_lvl == 2'd3)
        |=> cfg_q == ($past(acc_wdata) & CFG_WMASK));

    p_refused_keeps_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && priv_lvl != 2'd3) |=> $stable(cfg_q));

    p_refused_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_trap || acc_deny) |-> acc_rdata == '0);

    p_trap_deny_excl_r4: assert property (@(posedge clk) disable iff (rst)
        $countones({acc_trap, acc_deny}) <= 1);

    p_monitor_secure_r5: assert property (@(posedge clk) disable iff (rst)
        mon_mode |-> !eff_nonsec);

    p_no_wait_trap_mon_r7: assert property (@(posedge clk) disable iff (rst)
        mon_mode |-> (!wfi_trap && !wfe_trap));

    p_hvc_off_r8: assert property (@(posedge clk) disable iff (rst)
        (hvc_exec && !cfg_q[B_HVCON]) |-> hvc_undef);

    p_smc_hyp_first_r9: assert property (@(posedge clk) disable iff (rst)
        smc_to_hyp |-> !smc_undef);
endmodule

bind secfg_ctrl secfg_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_wdata  (acc_wdata),
    .priv_lvl   (priv_lvl),
    .mon_mode   (mon_mode),
    .acc_rdata  (acc_rdata),
    .acc_trap   (acc_trap),
    .acc_deny   (acc_deny),
    .eff_nonsec (eff_nonsec),
    .wfi_trap   (wfi_trap),
    .wfe_trap   (wfe_trap),
    .hvc_exec   (hvc_exec),
    .hvc_undef  (hvc_undef),
    .smc_to_hyp (smc_to_hyp),
    .smc_undef  (smc_undef),
    .cfg_q      (cfg_q)
);

// File: tb/tb_secfg_ctrl.sv
module tb_secfg_ctrl;
    localparam logic [31:0] MASK = 32'h0000_33BF;
    localparam int NV = 10;
    // {priv[34:33], write[32], data[31:0]}
    localparam logic [34:0] VEC [NV] = '{
        {2'd3, 1'b1, 32'hFFFF_FFFF},
        {2'd3, 1'b0, 32'h0},
        {2'd1, 1'b1, 32'h0},
        {2'd2, 1'b1, 32'h0},
        {2'd0, 1'b0, 32'h0},
        {2'd3, 1'b1, 32'h0},
        {2'd1, 1'b1, 32'hFFFF_FFFF},
        {2'd1, 1'b0, 32'h0},
        {2'd3, 1'b1, 32'hA5A5_A5A5},
        {2'd3, 1'b0, 32'h0}
    };

    logic clk = 0, rst = 1;
    logic acc_valid = 0, acc_write = 0, mon_mode = 0;
    logic [31:0] acc_wdata = 0;
    logic [1:0] priv_lvl = 0;
    logic [31:0] acc_rdata;
    logic acc_trap, acc_deny, eff_nonsec, irq_to_mon, fiq_to_mon, abt_to_mon;
    logic wfi_exec = 0, wfe_exec = 0, wake_pending = 0, event_reg = 0, other_exc = 0;
    logic wfi_trap, wfe_trap, hvc_exec = 0, hvc_undef;
    logic smc_exec = 0, smc_hyp_trap = 0, smc_to_hyp, smc_undef;
    logic fetch_ns_attr = 0, fetch_block;

    int total = 0, bad = 0, cyc = 0;
    logic [31:0] model = 0;

    always #10 clk = ~clk;

    secfg_ctrl dut (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            bad = bad + 1;
            $display("FAIL watchdog: act=timeout exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic [1:0] pv, input logic wr, input logic [31:0] d,
                          input string req);
        logic t_e, d_e;
        logic [31:0] r_e;
        @(negedge clk);
        priv_lvl = pv; acc_write = wr; acc_wdata = d; acc_valid = 1;
        #2;
        t_e = (pv == 2'd1) && !model[0];
        d_e = (pv != 2'd3) && !t_e;
        r_e = (pv == 2'd3 && !wr) ? model : 32'h0;
        chk({req, " trap"}, {31'b0, acc_trap}, {31'b0, t_e});
        chk({req, " deny"}, {31'b0, acc_deny}, {31'b0, d_e});
        chk({req, " rdata"}, acc_rdata, r_e);
        @(posedge clk);
        if (pv == 2'd3 && wr) model = d & MASK;
        @(negedge clk);
        acc_valid = 0; acc_write = 0; acc_wdata = 0;
    endtask

    task automatic readback(input string req);
        @(negedge clk);
        priv_lvl = 2'd3; acc_write = 0; acc_valid = 1;
        #2;
        chk(req, acc_rdata, model);
        @(negedge clk);
        acc_valid = 0;
    endtask

    task automatic set_cfg(input logic [31:0] d);
        access(2'd3, 1'b1, d, "R3 set");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        readback("R2 reset word");

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][34:33], VEC[i][32], VEC[i][31:0], "R1/R3/R4 vector");
            readback("R4 word after access");
        end

        // R5 effective state
        set_cfg(32'h1);
        @(negedge clk); mon_mode = 0; priv_lvl = 1; #2;
        chk("R5 nonsec", {31'b0, eff_nonsec}, 32'h1);
        mon_mode = 1; #2;
        chk("R5 monitor forces secure", {31'b0, eff_nonsec}, 32'h0);
        mon_mode = 0;

        // R6 routing
        set_cfg(32'hA);
        #2;
        chk("R6 routing", {29'b0, abt_to_mon, fiq_to_mon, irq_to_mon}, 32'h5);

        // R7 wait traps
        set_cfg(32'h3000);
        @(negedge clk); wfi_exec = 1; #2;
        chk("R7 wfi trap", {31'b0, wfi_trap}, 32'h1);
        wake_pending = 1; #2;
        chk("R7 wfi wake pending", {31'b0, wfi_trap}, 32'h0);
        wake_pending = 0; mon_mode = 1; #2;
        chk("R7 wfi in monitor", {31'b0, wfi_trap}, 32'h0);
        mon_mode = 0; wfi_exec = 0; wfe_exec = 1; event_reg = 1; #2;
        chk("R7 wfe event set", {31'b0, wfe_trap}, 32'h0);
        event_reg = 0; #2;
        chk("R7 wfe trap", {31'b0, wfe_trap}, 32'h1);
        other_exc = 1; #2;
        chk("R7 wfe other exception", {31'b0, wfe_trap}, 32'h0);
        other_exc = 0; wfe_exec = 0;

        // R8 hypervisor call
        set_cfg(32'h1);
        @(negedge clk); hvc_exec = 1; priv_lvl = 1; #2;
        chk("R8 disabled", {31'b0, hvc_undef}, 32'h1);
        hvc_exec = 0;
        set_cfg(32'h101);
        @(negedge clk); hvc_exec = 1; priv_lvl = 2; #2;
        chk("R8 enabled level 2", {31'b0, hvc_undef}, 32'h0);
        priv_lvl = 0; #2;
        chk("R8 enabled level 0", {31'b0, hvc_undef}, 32'h1);
        hvc_exec = 0;

        // R9 monitor call
        set_cfg(32'h81);
        @(negedge clk); smc_exec = 1; smc_hyp_trap = 1; priv_lvl = 1; #2;
        chk("R9 hyp trap first", {30'b0, smc_to_hyp, smc_undef}, 32'h2);
        smc_hyp_trap = 0; #2;
        chk("R9 disabled", {30'b0, smc_to_hyp, smc_undef}, 32'h1);
        smc_exec = 0;
        set_cfg(32'h1);
        @(negedge clk); smc_exec = 1; priv_lvl = 1; #2;
        chk("R9 enabled", {31'b0, smc_undef}, 32'h0);
        smc_exec = 0;

        // R10 fetch lock
        set_cfg(32'h200);
        @(negedge clk); fetch_ns_attr = 1; #2;
        chk("R10 blocked secure", {31'b0, fetch_block}, 32'h1);
        fetch_ns_attr = 0;
        set_cfg(32'h201);
        @(negedge clk); fetch_ns_attr = 1; #2;
        chk("R10 allowed nonsec", {31'b0, fetch_block}, 32'h0);
        fetch_ns_attr = 0;

        // R2 reset mid-run
        set_cfg(32'h33BF);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0; model = 0;
        readback("R2 reset mid-run");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule